// File: doc/BRIEF.md
# Serial Line Break and Idle Detector

This block watches one already-sampled asynchronous serial line and measures how long the line holds each level. An optional inversion input flips the polarity first, so the rest of the logic always treats high as the resting level. From the configured character format (data width, parity enable, stop length in half bits and bit period in clock cycles), the block computes the nominal length of one frame in samples. That length serves as the threshold for both conditions the block reports.

A low run of at least one frame length is a break. The break is reported when the line returns high, together with the measured low duration. A receive-restart pulse is issued at the same moment, so that a companion character receiver returns to hunting for a start bit. A high run produces an idle pulse each time it completes one more frame length, so pulses repeat for as long as the line stays high. The companion receiver supplies a frame-end strobe at the nominal end of each character it decodes, and the idle measurement is re-based to that point.

Top module: `line_break_idle_det`

## Requirements
- R1: Frame length L in samples equals ceil(H × P / 2), where P = `bit_period_i` and H = 2 + 2·`data_bits_i` + 2·`parity_en_i` + `stop_halves_i` is the frame length in half bits (one start bit, data bits 5 to 9, an optional parity bit, and the stop length given in half bits).
- R2: When the line turns high after a low run of n samples with n ≥ L, `break_o` is high for exactly one cycle. This happens in the cycle after the first high sample is taken, and `break_len_o` then shows n. `break_len_o` holds its value until the next break.
- R3: A low run of n < L samples produces no break pulse and leaves `break_len_o` unchanged.
- R4: No break pulse is raised while the line is still low, and a single low run yields at most one break.
- R5: The low-duration measurement saturates at 2^DUR_W − 1 instead of wrapping. A longer low run reports that maximum.
- R6: `rx_restart_o` pulses in the same cycle as every break pulse and at no other time.
- R7: After L consecutive high samples, `idle_o` is high for one cycle, in the cycle after the L-th sample. The count then restarts, so a continued high level gives a pulse every L samples.
- R8: A single low sample discards the idle measurement in progress. The next idle pulse needs L fresh high samples.
- R9: A high sample taken with `frame_end_i` set restarts the idle count at that point. The next idle pulse follows L samples after that sample, and no pulse is raised in that sample's own cycle.
- R10: With `invert_i` high, the line is treated with reversed polarity for both break and idle detection.
- R11: After reset, `break_o`, `idle_o` and `rx_restart_o` are low and `break_len_o` is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Sample clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| line_i | input | 1 | Sampled serial line |
| invert_i | input | 1 | Reverse line polarity |
| data_bits_i | input | 4 | Data bits per character (5 to 9) |
| parity_en_i | input | 1 | Parity bit present |
| stop_halves_i | input | 3 | Stop length in half bit times |
| bit_period_i | input | BP_W | Bit period in clock cycles |
| frame_end_i | input | 1 | Receiver strobe at nominal frame end |
| break_o | output | 1 | Break reported (one cycle) |
| break_len_o | output | DUR_W | Low duration of the last break, saturating |
| idle_o | output | 1 | One idle frame time elapsed (one cycle) |
| rx_restart_o | output | 1 | Force the receiver back to start-bit hunt |

## Verification
A wrong frame length shows as idle pulses that arrive early or late within L cycles of reset, and as breaks that are accepted or rejected at the wrong low-run boundary. The bench places low runs at L−1, L and L+2 samples to catch this. A low counter that is stale or never cleared shows on the very next rising edge as a wrong `break_len_o`, a missing pulse or a repeated pulse. A wrapping counter shows as a short duration after a run longer than its range. An idle counter that ignores a low sample or a frame-end strobe fires up to L cycles earlier than expected. That early pulse is visible within one frame time.

// File: rtl/lbi_pkg.sv
package lbi_pkg;
  localparam int unsigned DBITS_W = 4;
  localparam int unsigned STOP_W  = 3;
  localparam int unsigned HALF_W  = 6;  // holds 2 + 2*15 + 2 + 7

  typedef struct packed {
    logic [DBITS_W-1:0] data_bits;
    logic               parity_en;
    logic [STOP_W-1:0]  stop_halves;
  } fmt_t;
endpackage

// File: rtl/lbi_frame_len.sv
module lbi_frame_len
  import lbi_pkg::*;
#(
  parameter int unsigned BP_W  = 12,
  parameter int unsigned LEN_W = BP_W + 5
) (
  input  fmt_t             fmt_i,
  input  logic [BP_W-1:0]  bit_period_i,
  output logic [LEN_W-1:0] frame_len_o
);
  localparam int unsigned PROD_W = BP_W + HALF_W;

  logic [HALF_W-1:0] halves;
  logic [PROD_W-1:0] prod;
  logic [PROD_W-1:0] rounded;

  // frame length in half bits, then ceil(halves*period/2)
  assign halves  = HALF_W'(2) + (HALF_W'(fmt_i.data_bits) << 1)
                 + (HALF_W'(fmt_i.parity_en) << 1) + HALF_W'(fmt_i.stop_halves);
  assign prod    = PROD_W'(halves) * PROD_W'(bit_period_i);
  assign rounded = (prod + PROD_W'(1)) >> 1;
  assign frame_len_o = LEN_W'(rounded);
endmodule

// File: rtl/lbi_break_timer.sv
module lbi_break_timer #(
  parameter int unsigned DUR_W = 16,
  parameter int unsigned LEN_W = 17
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             level_i,
  input  logic [LEN_W-1:0] frame_len_i,
  output logic             break_o,
  output logic [DUR_W-1:0] break_len_o
);
  localparam int unsigned CMP_W = (DUR_W > LEN_W) ? DUR_W : LEN_W;

  logic [DUR_W-1:0] low_cnt;
  logic             rise;
  logic             long_enough;

  assign rise        = level_i && (low_cnt != '0);
  assign long_enough = CMP_W'(low_cnt) >= CMP_W'(frame_len_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      low_cnt     <= '0;
      break_o     <= 1'b0;
      break_len_o <= '0;
    end else begin
      break_o <= rise && long_enough;
      if (rise && long_enough) break_len_o <= low_cnt;
      if (level_i)               low_cnt <= '0;
      else if (low_cnt != '1)    low_cnt <= low_cnt + DUR_W'(1);  // saturate
    end
  end
endmodule

// File: rtl/lbi_idle_timer.sv
module lbi_idle_timer #(
  parameter int unsigned LEN_W = 17
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             level_i,
  input  logic             frame_end_i,
  input  logic [LEN_W-1:0] frame_len_i,
  output logic             idle_o
);
  logic [LEN_W-1:0] hi_cnt;
  logic [LEN_W-1:0] hi_nxt;

  assign hi_nxt = hi_cnt + LEN_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_cnt <= '0;
      idle_o <= 1'b0;
    end else if (!level_i || frame_end_i) begin
      hi_cnt <= '0;
      idle_o <= 1'b0;
    end else if (hi_nxt >= frame_len_i) begin
      hi_cnt <= '0;   // back-to-back idle periods
      idle_o <= 1'b1;
    end else begin
      hi_cnt <= hi_nxt;
      idle_o <= 1'b0;
    end
  end
endmodule

// File: rtl/line_break_idle_det.sv
module line_break_idle_det
  import lbi_pkg::*;
#(
  parameter int unsigned BP_W  = 12,
  parameter int unsigned DUR_W = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                line_i,
  input  logic                invert_i,
  input  logic [DBITS_W-1:0]  data_bits_i,
  input  logic                parity_en_i,
  input  logic [STOP_W-1:0]   stop_halves_i,
  input  logic [BP_W-1:0]     bit_period_i,
  input  logic                frame_end_i,
  output logic                break_o,
  output logic [DUR_W-1:0]    break_len_o,
  output logic                idle_o,
  output logic                rx_restart_o
);
  localparam int unsigned LEN_W = BP_W + 5;

  fmt_t             fmt;
  logic             level;
  logic [LEN_W-1:0] frame_len;

  assign fmt   = '{data_bits: data_bits_i, parity_en: parity_en_i, stop_halves: stop_halves_i};
  assign level = line_i ^ invert_i;

  lbi_frame_len #(.BP_W(BP_W), .LEN_W(LEN_W)) i_len (
    .fmt_i       (fmt),
    .bit_period_i(bit_period_i),
    .frame_len_o (frame_len)
  );

  lbi_break_timer #(.DUR_W(DUR_W), .LEN_W(LEN_W)) i_brk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .level_i    (level),
    .frame_len_i(frame_len),
    .break_o    (break_o),
    .break_len_o(break_len_o)
  );

  lbi_idle_timer #(.LEN_W(LEN_W)) i_idle (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .level_i    (level),
    .frame_end_i(frame_end_i),
    .frame_len_i(frame_len),
    .idle_o     (idle_o)
  );

  assign rx_restart_o = break_o;
endmodule

// File: rtl/lbi_checker.sv
module lbi_checker #(
  parameter int unsigned LEN_W = 17,
  parameter int unsigned DUR_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             level_i,
  input logic [LEN_W-1:0] frame_len_i,
  input logic             break_o,
  input logic [DUR_W-1:0] break_len_o,
  input logic             idle_o,
  input logic             rx_restart_o
);
  localparam int unsigned CMP_W = (DUR_W > LEN_W) ? DUR_W : LEN_W;

  AST_BREAK_AFTER_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    break_o |-> $past(level_i));  // R2
  AST_NO_BREAK_WHILE_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(level_i) |-> !break_o);  // R4
  AST_BREAK_MIN_LEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    break_o |-> CMP_W'(break_len_o) >= CMP_W'($past(frame_len_i)));  // R3
  AST_LEN_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !break_o |-> $stable(break_len_o));  // R2
  AST_RESTART_ONLY_ON_BREAK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rx_restart_o) |-> break_o);  // R6
  AST_IDLE_AFTER_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle_o |-> $past(level_i));  // R7
  AST_BREAK_IDLE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(frame_len_i) > LEN_W'(1)) |-> !(break_o && idle_o));  // R7
endmodule

bind line_break_idle_det lbi_checker #(.LEN_W(LEN_W), .DUR_W(DUR_W)) i_lbi_checker (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .level_i     (level),
  .frame_len_i (frame_len),
  .break_o     (break_o),
  .break_len_o (break_len_o),
  .idle_o      (idle_o),
  .rx_restart_o(rx_restart_o)
);

// File: tb/test_line_break_idle_det.sv
module test_line_break_idle_det;
  localparam int CLK_P = 10;
  localparam int BP_W  = 4;
  localparam int DUR_W = 10;
  localparam int DUR_MAX = (1 << DUR_W) - 1;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             line = 1'b1;
  logic             inv = 1'b0;
  logic [3:0]       dbits = 4'd8;
  logic             par = 1'b0;
  logic [2:0]       shalf = 3'd2;
  logic [BP_W-1:0]  bp = 4'd1;
  logic             fend = 1'b0;
  logic             brk;
  logic [DUR_W-1:0] blen;
  logic             idle;
  logic             rrst;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_P/2) clk = ~clk;

  line_break_idle_det #(.BP_W(BP_W), .DUR_W(DUR_W)) i_line_break_idle_det (
    .clk_i(clk), .rst_ni(rst_n), .line_i(line), .invert_i(inv),
    .data_bits_i(dbits), .parity_en_i(par), .stop_halves_i(shalf),
    .bit_period_i(bp), .frame_end_i(fend),
    .break_o(brk), .break_len_o(blen), .idle_o(idle), .rx_restart_o(rrst)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  // one sample: drive logical level, clock, outputs then reflect this sample
  task automatic step(input logic lvl, input logic fe);
    line = lvl ^ inv;
    fend = fe;
    @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    line = ~inv;
    fend = 1'b0;
    rst_n = 1'b0;
    @(posedge clk);
    @(posedge clk);
    #1;
    rst_n = 1'b1;
    chk(brk == 0 && idle == 0 && rrst == 0 && blen == 0, "R11 reset state",
        int'(blen), 0);
  endtask

  task automatic run_config(input int db, input int pa, input int sh, input int b,
                            input logic iv);
    int L;
    string t_idle;
    L = ((2 + 2*db + 2*pa + sh) * b + 1) / 2;
    dbits = 4'(db); par = pa[0]; shalf = 3'(sh); bp = BP_W'(b); inv = iv;
    t_idle = iv ? "R1 R7 R10 idle" : "R1 R7 idle";
    do_reset();
    // idle periods back to back
    for (int i = 1; i <= 2*L; i++) begin
      step(1'b1, 1'b0);
      chk(idle == ((i % L) == 0), t_idle, int'(idle), int'((i % L) == 0));
    end
    // low sample cancels idle timing
    for (int i = 1; i < L; i++) step(1'b1, 1'b0);
    step(1'b0, 1'b0);
    for (int i = 1; i < L; i++) begin
      step(1'b1, 1'b0);
      chk(idle == 0, "R8 cancel", int'(idle), 0);
    end
    step(1'b1, 1'b0);
    chk(idle == 1, "R8 fresh period", int'(idle), 1);
    // frame-end rebase
    for (int i = 0; i < 3; i++) step(1'b1, 1'b0);
    step(1'b1, 1'b1);
    chk(idle == 0, "R9 strobe cycle", int'(idle), 0);
    for (int i = 1; i < L; i++) begin
      step(1'b1, 1'b0);
      chk(idle == 0, "R9 rebased", int'(idle), 0);
    end
    step(1'b1, 1'b0);
    chk(idle == 1, "R9 rebased idle", int'(idle), 1);
    // break threshold boundary
    for (int d = -1; d <= 2; d += (d == 0) ? 2 : 1) begin
      int n;
      int prev_len;
      bit expb;
      n = L + d;
      prev_len = int'(blen);
      expb = (n >= L);
      for (int i = 0; i < n; i++) begin
        step(1'b0, 1'b0);
        chk(brk == 0 && rrst == 0, "R4 no break while low", int'(brk), 0);
      end
      step(1'b1, 1'b0);
      chk(brk == expb, expb ? "R2 R10 break" : "R3 short low", int'(brk), int'(expb));
      chk(rrst == expb, "R6 restart", int'(rrst), int'(expb));
      chk(int'(blen) == (expb ? n : prev_len), expb ? "R2 duration" : "R3 len kept",
          int'(blen), expb ? n : prev_len);
      step(1'b1, 1'b0);
      chk(brk == 0 && rrst == 0, "R4 single break", int'(brk), 0);
    end
  endtask

  initial begin
    #(CLK_P * 190000);
    n_fail++;
    $display("FAIL watchdog act=1 exp=0");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    int cfg;
    cfg = 0;
    foreach (dbits[k]) begin end
    for (int db = 5; db <= 9; db++)
      for (int pa = 0; pa <= 1; pa++)
        for (int sh = 0; sh <= 4; sh++)
          for (int b = 1; b <= 3; b++) begin
            run_config(db, pa, sh, b, cfg[0]);
            cfg++;
          end
    // saturation: L = 7
    run_config(5, 0, 2, 1, 1'b0);
    for (int i = 0; i < DUR_MAX + 80; i++) step(1'b0, 1'b0);
    step(1'b1, 1'b0);
    chk(brk == 1, "R5 long break", int'(brk), 1);
    chk(int'(blen) == DUR_MAX, "R5 saturated duration", int'(blen), DUR_MAX);
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule